// File: doc/BRIEF.md
# Toggle-Handshake Error Interrupt Controller

This block keeps a record of global error conditions in two equal-width registers and turns interrupt requests from several sources into single-cycle interrupt pulses. Hardware reports a new error by inverting bits of the error register. Software acknowledges an error by writing the acknowledge register so that the bit matches the error register again. A bit is pending while the two registers disagree in that bit. A new error report inverts only bits that are not already pending. The global-error interrupt fires only when at least one bit was actually inverted.

Four request sources feed the block: an event queue, command-sync completion, a page-request queue and global errors, which carry a bit mask. An interrupt control register holds an enable for the event-queue source and an enable for the global-error source. Command-sync completion always interrupts. Page-request interrupts are not supported. A small word-addressed register port lets software write the control and acknowledge registers and read all state. A sticky status flag records any acknowledge write that inverted bits that were not pending. The flag clears when it is read.

Register map (2-bit word address): 0 = interrupt control (bit 0 global-error enable, bit 1 event-queue enable), 1 = error register (read only), 2 = acknowledge register, 3 = status (bit 0 misuse flag, cleared by a read). Reads are combinational in the same cycle as `regRdEn`. A write takes effect at the clock edge where `regWrEn` is high.

Top module: `errIrqCtrl`

## Requirements
- R1: After reset, the control, error, acknowledge and status registers read 0, and all four interrupt outputs are low.
- R2: The pending set is error XOR acknowledge. On a global-error request, exactly the bits of (mask AND NOT pending) in the error register invert at that clock edge. Software reads the result at address 1.
- R3: When a global-error request's mask holds only pending bits, the error register is unchanged and `gerrIrq` stays low.
- R4: When a global-error request inverts at least one bit, `gerrIrq` is high in the cycle after the request only if control bit 0 is set. With the bit clear, the error bits still invert but no pulse occurs.
- R5: An event-queue request pulses `evtqIrq` in the next cycle only when control bit 1 is set.
- R6: A command-sync request pulses `cmdSyncIrq` in the next cycle whatever the control register holds.
- R7: A page-request-queue request never produces a pulse on `priqIrq`.
- R8: A write to address 2 stores the full written value in the acknowledge register, including bits that were not pending, and no error response results.
- R9: Status bit 0 becomes 1 after an acknowledge write that inverts any bit that was not pending. A read of address 3 returns it and then clears it. An acknowledge write that inverts only pending bits leaves it 0.
- R10: Requests from different sources in the same cycle are each handled by their own rule.
- R11: When a global-error request and an acknowledge write fall in the same cycle, the bits to invert are computed from the acknowledge value held before the write.
- R12: Each interrupt pulse lasts exactly one clock cycle for a one-cycle request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evtqReq | input | 1 | Event-queue interrupt request |
| cmdSyncReq | input | 1 | Command-sync completion request |
| priqReq | input | 1 | Page-request-queue interrupt request |
| gerrReq | input | 1 | Global-error request |
| gerrMask | input | ERR_W | Error bits reported with the global-error request |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (clears status on address 3) |
| regAddr | input | 2 | Register word address |
| regWrData | input | ERR_W | Register write data |
| regRdData | output | ERR_W | Register read data |
| evtqIrq | output | 1 | Event-queue interrupt pulse |
| cmdSyncIrq | output | 1 | Command-sync interrupt pulse |
| priqIrq | output | 1 | Page-request-queue interrupt pulse |
| gerrIrq | output | 1 | Global-error interrupt pulse |

## Verification
The hardest case to reach from the ports is an error report and an acknowledge write at the same clock edge, where the acknowledge value that counts is the old one. The bench first brings both registers to equal values, so nothing is pending. In one cycle it then raises a global-error request and writes an acknowledge value that already has the reported bit inverted. The error register must invert, the pulse must fire and the misuse flag must set. Reading the new acknowledge value would mask the bit and suppress all three. A second hard-to-reach state is a mask that mixes pending and new bits, which the bench sets up through a partial acknowledge before it reports again.

// File: rtl/errIrqPkg.sv
package errIrqPkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_ERR  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_ACK  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd3;

  localparam int CTL_GERR_EN = 0;
  localparam int CTL_EVTQ_EN = 1;

  localparam int NUM_SRC  = 4;
  localparam int SRC_EVTQ = 0;
  localparam int SRC_CMD  = 1;
  localparam int SRC_PRIQ = 2;
  localparam int SRC_GERR = 3;

  typedef struct packed {
    logic gerrApply;
    logic ctlWr;
    logic ackWr;
    logic statusRd;
  } ctrlStrobes_t;
endpackage

// File: rtl/errIrqControl.sv
module errIrqControl
  import errIrqPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 evtqReq,
  input  logic                 cmdSyncReq,
  input  logic                 priqReq,
  input  logic                 gerrReq,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 newErrAny,
  input  logic                 gerrEn,
  input  logic                 evtqEn,
  output ctrlStrobes_t         strobes,
  output logic [NUM_SRC-1:0]   irqPulse
);
  logic [NUM_SRC-1:0] fire;

  always_comb begin
    strobes.gerrApply = gerrReq;
    strobes.ctlWr     = regWrEn && (regAddr == ADDR_CTL);
    strobes.ackWr     = regWrEn && (regAddr == ADDR_ACK);
    strobes.statusRd  = regRdEn && (regAddr == ADDR_STAT);
  end

  always_comb begin
    fire[SRC_EVTQ] = evtqReq && evtqEn;
    fire[SRC_CMD]  = cmdSyncReq;
    // page-request interrupts are not supported: the request is dropped
    fire[SRC_PRIQ] = priqReq && 1'b0;
    fire[SRC_GERR] = gerrReq && newErrAny && gerrEn;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_pulse
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) irqPulse[s] <= 1'b0;
      else       irqPulse[s] <= fire[s];
    end
  end
endmodule

// File: rtl/errIrqDatapath.sv
module errIrqDatapath
  import errIrqPkg::*;
#(
  parameter int ERR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [ERR_W-1:0]   gerrMask,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [ERR_W-1:0]   regWrData,
  output logic               newErrAny,
  output logic               gerrEn,
  output logic               evtqEn,
  output logic [ERR_W-1:0]   errVal,
  output logic [ERR_W-1:0]   ackVal,
  output logic [ERR_W-1:0]   regRdData
);
  logic [ERR_W-1:0] errReg, ackReg, pendingBits, newBits, ackToggled;
  logic [1:0]       ctlReg;
  logic             misuseFlag, misuseNow;

  always_comb begin
    pendingBits = errReg ^ ackReg;
    newBits     = strobes.gerrApply ? (gerrMask & ~pendingBits) : '0;
    newErrAny   = |newBits;
    ackToggled  = ackReg ^ regWrData;
    misuseNow   = strobes.ackWr && |(ackToggled & ~pendingBits);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errReg     <= '0;
      ackReg     <= '0;
      ctlReg     <= '0;
      misuseFlag <= 1'b0;
    end else begin
      errReg <= errReg ^ newBits;
      if (strobes.ackWr) ackReg <= regWrData;
      if (strobes.ctlWr) ctlReg <= regWrData[1:0];
      if (misuseNow)             misuseFlag <= 1'b1;
      else if (strobes.statusRd) misuseFlag <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_CTL:  regRdData[1:0] = ctlReg;
      ADDR_ERR:  regRdData      = errReg;
      ADDR_ACK:  regRdData      = ackReg;
      ADDR_STAT: regRdData[0]   = misuseFlag;
      default:   regRdData      = '0;
    endcase
  end

  assign gerrEn = ctlReg[CTL_GERR_EN];
  assign evtqEn = ctlReg[CTL_EVTQ_EN];
  assign errVal = errReg;
  assign ackVal = ackReg;
endmodule

// File: rtl/errIrqCtrl.sv
module errIrqCtrl
  import errIrqPkg::*;
#(
  parameter int ERR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtqReq,
  input  logic              cmdSyncReq,
  input  logic              priqReq,
  input  logic              gerrReq,
  input  logic [ERR_W-1:0]  gerrMask,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [ERR_W-1:0]  regWrData,
  output logic [ERR_W-1:0]  regRdData,
  output logic              evtqIrq,
  output logic              cmdSyncIrq,
  output logic              priqIrq,
  output logic              gerrIrq
);
  ctrlStrobes_t       strobes;
  logic [NUM_SRC-1:0] irqPulse;
  logic               newErrAny, gerrEn, evtqEn;
  logic [ERR_W-1:0]   errVal, ackVal;

  errIrqControl ctl_i (
    .clk(clk), .rstN(rstN),
    .evtqReq(evtqReq), .cmdSyncReq(cmdSyncReq), .priqReq(priqReq), .gerrReq(gerrReq),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .newErrAny(newErrAny), .gerrEn(gerrEn), .evtqEn(evtqEn),
    .strobes(strobes), .irqPulse(irqPulse)
  );

  errIrqDatapath #(.ERR_W(ERR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .gerrMask(gerrMask),
    .regAddr(regAddr), .regWrData(regWrData),
    .newErrAny(newErrAny), .gerrEn(gerrEn), .evtqEn(evtqEn),
    .errVal(errVal), .ackVal(ackVal), .regRdData(regRdData)
  );

  assign evtqIrq    = irqPulse[SRC_EVTQ];
  assign cmdSyncIrq = irqPulse[SRC_CMD];
  assign priqIrq    = irqPulse[SRC_PRIQ];
  assign gerrIrq    = irqPulse[SRC_GERR];
endmodule

// File: rtl/errIrqCtrlChecker.sv
module errIrqCtrlChecker #(
  parameter int ERR_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             evtqReq,
  input logic             cmdSyncReq,
  input logic             gerrReq,
  input logic [ERR_W-1:0] gerrMask,
  input logic             evtqIrq,
  input logic             cmdSyncIrq,
  input logic             priqIrq,
  input logic             gerrIrq,
  input logic [ERR_W-1:0] errVal,
  input logic [ERR_W-1:0] ackVal
);
  AST_PRIQ_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !priqIrq); // R7

  AST_CMDSYNC_ALWAYS: assert property (@(posedge clk) disable iff (!rstN)
    cmdSyncReq |=> cmdSyncIrq); // R6

  AST_EVTQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    evtqIrq |-> $past(evtqReq)); // R5

  AST_GERR_NEEDS_NEW: assert property (@(posedge clk) disable iff (!rstN)
    gerrIrq |-> ($past(gerrReq) &&
                 (($past(gerrMask) & ~($past(errVal) ^ $past(ackVal))) != '0))); // R3

  AST_PENDING_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    ((errVal ^ $past(errVal)) & $past(errVal ^ ackVal)) == '0); // R2

  AST_ERR_FLIP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !$past(gerrReq) |-> errVal == $past(errVal)); // R2
endmodule

bind errIrqCtrl errIrqCtrlChecker #(.ERR_W(ERR_W)) chk_i (
  .clk(clk), .rstN(rstN), .evtqReq(evtqReq), .cmdSyncReq(cmdSyncReq),
  .gerrReq(gerrReq), .gerrMask(gerrMask), .evtqIrq(evtqIrq),
  .cmdSyncIrq(cmdSyncIrq), .priqIrq(priqIrq), .gerrIrq(gerrIrq),
  .errVal(errVal), .ackVal(ackVal)
);

// File: tb/errIrqCtrl_tb_top.sv
module errIrqCtrl_tb_top;
  localparam int W = 32;
  logic clk = 1'b0, rstN = 1'b0;
  logic evtqReq = 0, cmdSyncReq = 0, priqReq = 0, gerrReq = 0;
  logic [W-1:0] gerrMask = '0, regWrData = '0;
  logic regWrEn = 0, regRdEn = 0;
  logic [1:0] regAddr = '0;
  logic [W-1:0] regRdData;
  logic evtqIrq, cmdSyncIrq, priqIrq, gerrIrq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  errIrqCtrl #(.ERR_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .evtqReq(evtqReq), .cmdSyncReq(cmdSyncReq),
    .priqReq(priqReq), .gerrReq(gerrReq), .gerrMask(gerrMask),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evtqIrq(evtqIrq),
    .cmdSyncIrq(cmdSyncIrq), .priqIrq(priqIrq), .gerrIrq(gerrIrq)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [1:0] a, logic [W-1:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 0;
  endtask

  task automatic rdReg(logic [1:0] a, output logic [W-1:0] d);
    regRdEn = 1; regAddr = a; #0.5;
    d = regRdData;
    tick();
    regRdEn = 0;
  endtask

  // pulse request vector {gerr,priq,cmd,evtq}; check outputs next cycle and cycle after
  task automatic reqAndCheck(string req, logic [3:0] r, logic [W-1:0] m, logic [3:0] expIrq);
    {gerrReq, priqReq, cmdSyncReq, evtqReq} = r; gerrMask = m;
    tick();
    {gerrReq, priqReq, cmdSyncReq, evtqReq} = '0; gerrMask = '0;
    chk(req, {28'd0, gerrIrq, priqIrq, cmdSyncIrq, evtqIrq}, {28'd0, expIrq});
    tick();
    chk("R12", {28'd0, gerrIrq, priqIrq, cmdSyncIrq, evtqIrq}, '0);
  endtask

  task automatic testReset();
    logic [W-1:0] d;
    for (int a = 0; a < 4; a++) begin
      rdReg(a[1:0], d);
      chk("R1", d, '0);
    end
    chk("R1", {28'd0, gerrIrq, priqIrq, cmdSyncIrq, evtqIrq}, '0);
  endtask

  task automatic testEvtq();
    wrReg(2'd0, 32'h0);
    reqAndCheck("R5", 4'b0001, '0, 4'b0000);
    wrReg(2'd0, 32'h2);
    reqAndCheck("R5", 4'b0001, '0, 4'b0001);
  endtask

  task automatic testCmdPriq();
    wrReg(2'd0, 32'h0);
    reqAndCheck("R6", 4'b0010, '0, 4'b0010);
    wrReg(2'd0, 32'h3);
    reqAndCheck("R7", 4'b0100, '0, 4'b0000);
  endtask

  task automatic testGerr();
    logic [W-1:0] d;
    wrReg(2'd0, 32'h1);
    reqAndCheck("R4", 4'b1000, 32'h5, 4'b1000);
    rdReg(2'd1, d); chk("R2", d, 32'h5);
    reqAndCheck("R2", 4'b1000, 32'hF, 4'b1000);
    rdReg(2'd1, d); chk("R2", d, 32'hF);
    reqAndCheck("R3", 4'b1000, 32'h3, 4'b0000);
    rdReg(2'd1, d); chk("R3", d, 32'hF);
    wrReg(2'd2, 32'h1);
    rdReg(2'd2, d); chk("R8", d, 32'h1);
    reqAndCheck("R2", 4'b1000, 32'h3, 4'b1000);
    rdReg(2'd1, d); chk("R2", d, 32'hE);
    wrReg(2'd2, 32'hE);
    wrReg(2'd0, 32'h0);
    reqAndCheck("R4", 4'b1000, 32'h10, 4'b0000);
    rdReg(2'd1, d); chk("R4", d, 32'h1E);
    wrReg(2'd2, 32'h1E);
    rdReg(2'd3, d); chk("R9", d, 32'h0);
  endtask

  task automatic testMisuse();
    logic [W-1:0] d;
    wrReg(2'd2, 32'h11E);
    rdReg(2'd2, d); chk("R8", d, 32'h11E);
    rdReg(2'd3, d); chk("R9", d, 32'h1);
    rdReg(2'd3, d); chk("R9", d, 32'h0);
    wrReg(2'd2, 32'h1E);
    rdReg(2'd3, d); chk("R9", d, 32'h0);
  endtask

  task automatic testSimul();
    logic [W-1:0] d;
    wrReg(2'd0, 32'h3);
    reqAndCheck("R10", 4'b1111, 32'h20, 4'b1011);
    rdReg(2'd1, d); chk("R10", d, 32'h3E);
    wrReg(2'd2, 32'h3E);
  endtask

  task automatic testSameCycle();
    logic [W-1:0] d;
    gerrReq = 1; gerrMask = 32'h40;
    regWrEn = 1; regAddr = 2'd2; regWrData = 32'h7E;
    tick();
    gerrReq = 0; gerrMask = '0; regWrEn = 0;
    chk("R11", {31'd0, gerrIrq}, 32'h1);
    tick();
    rdReg(2'd1, d); chk("R11", d, 32'h7E);
    rdReg(2'd2, d); chk("R11", d, 32'h7E);
    rdReg(2'd3, d); chk("R11", d, 32'h1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    tick();
    testReset();
    testEvtq();
    testCmdPriq();
    testGerr();
    testMisuse();
    testSimul();
    testSameCycle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule